// File: doc/BRIEF.md
# Keyed Row-Programming Controller

This block lets a processor program its own flash one row at a time through a small register file written over a valid/ready bus. Software places a word address in two address bytes, a data word in two data bytes, unlocks with a two-byte key written to the key register, and then sets the start bit in the control register. In latch-only mode the data word lands in one of the row latches. With latch-only clear, the current word is latched and the whole row of latches is committed to the flash model in one operation.

A transfer is accepted on a cycle where `bus_valid` and `bus_ready` are both high. The requester must hold `bus_valid`, `bus_sel` and `bus_wdata` steady until it is accepted. `bus_ready` is low only while row programming runs, and `stall` is high for those same cycles, so the processor stops issuing transfers there. For the two cycles after an accepted start, transfers are still accepted but have no effect, which mirrors the two instruction slots a processor lets go by after it starts a write.

The flash is modelled inside the block with a fixed programming time of `PROG_CYCLES` cycles. The committed row is also shown on a programming port (`pgm_go`, `pgm_cfg`, `pgm_row`, `pgm_data`) for the length of the stall.

Top module: `flash_row_writer`

## Requirements
- R1: After reset `bus_ready`=1, `stall`=0, `wr_active`=0, `pgm_go`=0, and every row latch holds 16'hFFFF.
- R2: Register select codes are 0 address low, 1 address high, 2 data low, 3 data high, 4 control, 5 key. A start is honoured only when the two accepted transfers before it were key=8'h55 and then key=8'hAA. Any other accepted transfer in between cancels the unlock.
- R3: Control bit 0 is start and bit 1 is write enable. A start written with bit 1 clear does nothing.
- R4: When control bit 2 (latch-only) is 1, a honoured start writes {data high, data low} into the latch at address bits [3:0]. No `pgm_go` follows.
- R5: When control bit 2 is 0, a honoured start first latches the current word, then pulses `pgm_go` for one cycle with `pgm_row` = address bits [15:4] and `pgm_data` holding latch i at bits [16i+15:16i].
- R6: Control bit 3 on the committing start selects the configuration region and is shown on `pgm_cfg`.
- R7: The two cycles after a honoured start accept transfers and discard them.
- R8: On a row commit, `stall` rises the cycle after the second ignored slot and stays high for exactly `PROG_CYCLES` cycles. `pgm_go` is high in the first of them, and `bus_ready` is low for all of them.
- R9: `wr_active` is high from the cycle after a honoured start. It clears after the two slots for a latch load, and after the last stall cycle for a row commit.
- R10: After a row commit every latch is back to 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register write request |
| bus_ready | output | 1 | Register write may be accepted |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 8 | Register write data |
| stall | output | 1 | Processor hold during row programming |
| wr_active | output | 1 | Start bit status, self-clearing |
| pgm_go | output | 1 | One-cycle row commit strobe |
| pgm_cfg | output | 1 | Commit targets configuration region |
| pgm_row | output | 12 | Row number of the commit |
| pgm_data | output | 256 | All row latches, word i at [16i+15:16i] |

## Verification
The bench splits the unlock pair with a data write and also sends it in reverse order. A tracker that only remembers seeing each byte would then start a write. It sends a valid unlock with write enable clear, which a design that ignores the enable bit would act on. It writes the address during the two ignored slots: if those writes leaked through, a later latch load would land in the wrong slot. It also commits twice in a row, so a design that forgets to erase the latches would carry old words into the second row. Stall length and unloaded latch values are compared against exact counts and all-ones words.

// File: rtl/flash_row_writer_pkg.sv
package flash_row_writer_pkg;
  localparam logic [2:0] SEL_ADDR_LO = 3'd0;
  localparam logic [2:0] SEL_ADDR_HI = 3'd1;
  localparam logic [2:0] SEL_DATA_LO = 3'd2;
  localparam logic [2:0] SEL_DATA_HI = 3'd3;
  localparam logic [2:0] SEL_CTRL    = 3'd4;
  localparam logic [2:0] SEL_KEY     = 3'd5;

  localparam logic [7:0] UNLOCK_A = 8'h55;
  localparam logic [7:0] UNLOCK_B = 8'hAA;

  localparam int CB_START = 0;
  localparam int CB_WEN   = 1;
  localparam int CB_LONLY = 2;
  localparam int CB_CFG   = 3;

  typedef enum logic [1:0] {PH_IDLE, PH_SLOT, PH_PROG} phase_e;
  typedef enum logic [1:0] {UK_NONE, UK_HALF, UK_ARMED} unlock_e;
endpackage

// File: rtl/unlock_tracker.sv
module unlock_tracker
  import flash_row_writer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic [2:0] sel,
  input  logic [7:0] wdata,
  output logic       armed
);
  unlock_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= UK_NONE;
    else if (beat) begin
      if (sel == SEL_KEY && wdata == UNLOCK_A)                       st_q <= UK_HALF;
      else if (st_q == UK_HALF && sel == SEL_KEY && wdata == UNLOCK_B) st_q <= UK_ARMED;
      else                                                           st_q <= UK_NONE;
    end
  end

  assign armed = (st_q == UK_ARMED);

  // R2: armed only straight after a half-unlock, or held with no traffic
  assert_armed_after_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == UK_ARMED) |-> ($past(st_q) == UK_HALF || ($past(st_q) == UK_ARMED && !$past(beat))));
  // R2: half-unlock only after a 0x55 key write or idle hold
  assert_half_after_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == UK_HALF) |-> (($past(beat) && $past(sel) == SEL_KEY && $past(wdata) == UNLOCK_A)
                           || ($past(st_q) == UK_HALF && !$past(beat))));
endmodule

// File: rtl/row_latch_bank.sv
module row_latch_bank #(
  parameter int WORDS  = 16,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [IDX_W-1:0]        idx,
  input  logic [WORD_W-1:0]       word,
  input  logic                    erase,
  output logic [WORDS*WORD_W-1:0] row_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_lat
    logic [WORD_W-1:0] lat_q;
    always_ff @(posedge clk) begin
      if (!rst_n || erase)                  lat_q <= '1;
      else if (load && idx == IDX_W'(g))    lat_q <= word;
    end
    assign row_o[g*WORD_W +: WORD_W] = lat_q;
  end

  // R10: all latches erased one cycle after a commit completes
  assert_erased_after_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(erase) |-> (row_o == '1));
endmodule

// File: rtl/flash_model.sv
module flash_model #(
  parameter int ROWS        = 8,
  parameter int WORDS       = 16,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 40,
  parameter int ROWSEL_W    = 12,
  localparam int ROW_BITS   = WORDS * WORD_W,
  localparam int RI_W       = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                cfg,
  input  logic [ROWSEL_W-1:0] row,
  input  logic [ROW_BITS-1:0] data,
  output logic                busy,
  output logic                done
);
  logic [ROW_BITS-1:0] main_q [ROWS];
  logic [ROW_BITS-1:0] cfg_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                row_ok;

  assign row_ok = (row < ROWSEL_W'(ROWS));
  assign done   = busy && (cnt_q == CNT_W'(PROG_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (go) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (done) begin
      busy  <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (done) begin
      if (cfg)         cfg_q <= data;
      else if (row_ok) main_q[row[RI_W-1:0]] <= data;
    end
  end

  // R8: no new commit while programming
  assert_no_go_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !go);
  // R5: the committed row is stored in the main region
  assert_row_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && !$past(cfg) && $past(row_ok)) |-> (main_q[$past(row[RI_W-1:0])] == $past(data)));
  // R6: a configuration commit lands in the configuration row
  assert_cfg_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && $past(cfg)) |-> (cfg_q == $past(data)));
endmodule

// File: rtl/flash_row_writer.sv
module flash_row_writer
  import flash_row_writer_pkg::*;
#(
  parameter int ROWS         = 8,
  parameter int WORDS        = 16,
  parameter int PROG_CYCLES  = 40,
  parameter int IGNORE_SLOTS = 2,
  localparam int WORD_W      = 16,
  localparam int ADDR_W      = 16,
  localparam int IDX_W       = $clog2(WORDS),
  localparam int ROWSEL_W    = ADDR_W - IDX_W,
  localparam int SLOT_W      = $clog2(IGNORE_SLOTS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_valid,
  output logic                      bus_ready,
  input  logic [2:0]                bus_sel,
  input  logic [7:0]                bus_wdata,
  output logic                      stall,
  output logic                      wr_active,
  output logic                      pgm_go,
  output logic                      pgm_cfg,
  output logic [ROWSEL_W-1:0]       pgm_row,
  output logic [WORDS*WORD_W-1:0]   pgm_data
);
  phase_e            phase_q;
  logic [SLOT_W-1:0] slot_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        dlo_q, dhi_q;
  logic              commit_q, armed, beat, start_ok, flash_go, flash_busy, flash_done;

  assign bus_ready = (phase_q != PH_PROG);
  assign stall     = (phase_q == PH_PROG);
  assign beat      = bus_valid && bus_ready && (phase_q == PH_IDLE);
  assign start_ok  = beat && bus_sel == SEL_CTRL && bus_wdata[CB_START]
                     && bus_wdata[CB_WEN] && armed;
  assign flash_go  = (phase_q == PH_SLOT) && (slot_q == SLOT_W'(IGNORE_SLOTS - 1)) && commit_q;

  unlock_tracker u_key (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sel(bus_sel), .wdata(bus_wdata), .armed(armed)
  );

  row_latch_bank #(.WORDS(WORDS), .WORD_W(WORD_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .idx(addr_q[IDX_W-1:0]),
    .word({dhi_q, dlo_q}), .erase(flash_done), .row_o(pgm_data)
  );

  flash_model #(.ROWS(ROWS), .WORDS(WORDS), .WORD_W(WORD_W),
                .PROG_CYCLES(PROG_CYCLES), .ROWSEL_W(ROWSEL_W)) u_flash (
    .clk(clk), .rst_n(rst_n), .go(flash_go), .cfg(pgm_cfg), .row(pgm_row),
    .data(pgm_data), .busy(flash_busy), .done(flash_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      dlo_q  <= '0;
      dhi_q  <= '0;
    end else if (beat) begin
      case (bus_sel)
        SEL_ADDR_LO: addr_q[7:0]  <= bus_wdata;
        SEL_ADDR_HI: addr_q[15:8] <= bus_wdata;
        SEL_DATA_LO: dlo_q        <= bus_wdata;
        SEL_DATA_HI: dhi_q        <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      slot_q    <= '0;
      commit_q  <= 1'b0;
      wr_active <= 1'b0;
      pgm_go    <= 1'b0;
      pgm_cfg   <= 1'b0;
      pgm_row   <= '0;
    end else begin
      pgm_go <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_ok) begin
          phase_q   <= PH_SLOT;
          slot_q    <= '0;
          commit_q  <= !bus_wdata[CB_LONLY];
          pgm_cfg   <= bus_wdata[CB_CFG];
          pgm_row   <= addr_q[ADDR_W-1:IDX_W];
          wr_active <= 1'b1;
        end
        PH_SLOT: begin
          slot_q <= slot_q + 1'b1;
          if (slot_q == SLOT_W'(IGNORE_SLOTS - 1)) begin
            if (commit_q) begin
              phase_q <= PH_PROG;
              pgm_go  <= 1'b1;
            end else begin
              phase_q   <= PH_IDLE;
              wr_active <= 1'b0;
            end
          end
        end
        PH_PROG: if (flash_done) begin
          phase_q   <= PH_IDLE;
          wr_active <= 1'b0;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R7: a commit strobe only follows the ignored slots
  assert_go_after_slots_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_go |-> ($past(phase_q) == PH_SLOT));
  // R8: the commit strobe falls inside the stall window while the flash runs
  assert_go_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_go |-> (stall && flash_busy));
  // R9: start status clears once programming completes
  assert_clear_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flash_done) |-> (!wr_active && !stall));
  // R4: a latch-only start never reaches the flash
  assert_latch_only_no_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) == PH_SLOT && !commit_q) |-> !pgm_go);
endmodule

// File: tb/tb_flash_row_writer.sv
`timescale 1ns/1ps
module tb_flash_row_writer;
  localparam int P = 40;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_ready;
  logic [2:0] bus_sel = 0;
  logic [7:0] bus_wdata = 0;
  logic stall, wr_active, pgm_go, pgm_cfg;
  logic [11:0] pgm_row;
  logic [255:0] pgm_data;

  always #2 clk = ~clk;

  flash_row_writer #(.PROG_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .stall(stall), .wr_active(wr_active),
    .pgm_go(pgm_go), .pgm_cfg(pgm_cfg), .pgm_row(pgm_row), .pgm_data(pgm_data));

  int runs = 0, fails = 0;
  int stall_cnt = 0, go_cnt = 0, leak_cnt = 0;
  logic [255:0] go_data;
  logic [11:0] go_row;
  logic go_cfg;
  logic [15:0] exp_row [16];

  always @(negedge clk) if (rst_n) begin
    if (stall) stall_cnt++;
    if (stall && bus_ready) leak_cnt++;
    if (pgm_go) begin go_cnt++; go_data = pgm_data; go_row = pgm_row; go_cfg = pgm_cfg; end
  end

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    runs++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    while (!bus_ready) @(negedge clk);
    bus_valid = 1; bus_sel = s; bus_wdata = d;
    @(posedge clk); #1 bus_valid = 0;
  endtask

  task automatic stage(input logic [11:0] row, input logic [3:0] idx, input logic [15:0] w);
    wr(3'd0, {row[3:0], idx}); wr(3'd1, {4'h0, row[11:4]});
    wr(3'd2, w[7:0]); wr(3'd3, w[15:8]);
  endtask

  task automatic start(input bit lonly, input bit cfg, input bit wen);
    wr(3'd5, 8'h55); wr(3'd5, 8'hAA);
    wr(3'd4, {4'h0, cfg, lonly, wen, 1'b1});
  endtask

  task automatic settle();
    @(negedge clk);
    while (wr_active) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic erase_exp();
    for (int i = 0; i < 16; i++) exp_row[i] = 16'hFFFF;
  endtask

  function automatic logic [255:0] pack_exp();
    logic [255:0] r;
    for (int i = 0; i < 16; i++) r[i*16 +: 16] = exp_row[i];
    return r;
  endfunction

  localparam logic [19:0] VEC [6] = '{20'h0_1111, 20'h1_2222, 20'h4_A5A5,
                                      20'h9_0F0F, 20'hC_BEEF, 20'hE_7E81};

  initial begin
    #(4 * 200000);
    fails++; runs++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int g0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_ready && !stall && !wr_active && !pgm_go, "R1 reset outputs",
        {bus_ready, stall, wr_active, pgm_go}, 4'b1000);

    // table walk: latch-only loads on row 2
    erase_exp();
    foreach (VEC[k]) begin
      g0 = go_cnt;
      stage(12'h002, VEC[k][19:16], VEC[k][15:0]);
      start(1'b1, 1'b0, 1'b1);
      @(negedge clk);
      chk(wr_active === 1'b1, "R9 active after latch start", wr_active, 1);
      @(negedge clk); @(negedge clk);
      chk(wr_active === 1'b0, "R9 latch start clears after slots", wr_active, 0);
      chk(go_cnt == g0, "R4 latch-only gives no commit", go_cnt, g0);
      exp_row[VEC[k][19:16]] = VEC[k][15:0];
    end

    // commit row 2 with last word at index 15
    g0 = go_cnt; stall_cnt = 0;
    stage(12'h002, 4'hF, 16'h1234);
    start(1'b0, 1'b0, 1'b1);
    exp_row[15] = 16'h1234;
    settle();
    chk(go_cnt == g0 + 1, "R5 one commit strobe", go_cnt, g0 + 1);
    chk(go_row == 12'h002, "R5 commit row", go_row, 2);
    chk(go_data == pack_exp(), "R5 committed row data", go_data, pack_exp());
    chk(go_data[7*16 +: 16] == 16'hFFFF, "R1 unloaded latch erased from reset", go_data[7*16 +: 16], 16'hFFFF);
    chk(go_cfg == 1'b0, "R6 main region", go_cfg, 0);
    chk(stall_cnt == P, "R8 stall length", stall_cnt, P);
    chk(leak_cnt == 0, "R8 bus blocked during stall", leak_cnt, 0);
    chk(wr_active == 1'b0, "R9 cleared after commit", wr_active, 0);

    // R2: unlock broken by another transfer, and reversed order
    stage(12'h003, 4'h1, 16'hDEAD);
    wr(3'd5, 8'h55); wr(3'd2, 8'hAD); wr(3'd5, 8'hAA); wr(3'd4, 8'h03);
    @(negedge clk);
    chk(wr_active == 1'b0, "R2 split unlock ignored", wr_active, 0);
    wr(3'd5, 8'hAA); wr(3'd5, 8'h55); wr(3'd4, 8'h03);
    @(negedge clk);
    chk(wr_active == 1'b0, "R2 reversed unlock ignored", wr_active, 0);

    // R3: valid unlock but write enable clear
    start(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk(wr_active == 1'b0, "R3 start without enable ignored", wr_active, 0);

    // R6 + R10: configuration commit right after a row commit
    g0 = go_cnt;
    erase_exp();
    stage(12'h000, 4'hF, 16'hBEEF);
    start(1'b0, 1'b1, 1'b1);
    exp_row[15] = 16'hBEEF;
    settle();
    chk(go_cnt == g0 + 1 && go_cfg == 1'b1, "R6 config region commit", go_cfg, 1);
    chk(go_data == pack_exp(), "R10 latches erased by previous commit", go_data, pack_exp());

    // R7: address writes in the two ignored slots are dropped
    erase_exp();
    stage(12'h005, 4'h3, 16'hAAAA);
    start(1'b1, 1'b0, 1'b1);
    wr(3'd0, 8'h55); wr(3'd0, 8'h55);
    settle();
    wr(3'd2, 8'hCC); wr(3'd3, 8'hBB);
    start(1'b1, 1'b0, 1'b1);
    exp_row[3] = 16'hBBCC;
    settle();
    stage(12'h005, 4'hF, 16'h0001);
    start(1'b0, 1'b0, 1'b1);
    exp_row[15] = 16'h0001;
    settle();
    chk(go_data[5*16 +: 16] == 16'hFFFF, "R7 slot write did not move address", go_data[5*16 +: 16], 16'hFFFF);
    chk(go_data == pack_exp(), "R7 second load hit original slot", go_data, pack_exp());
    chk(go_row == 12'h005, "R5 row 5 commit", go_row, 5);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule